// File: doc/BRIEF.md
# Addressed Discrete I/O Line Controller

This peripheral holds a bank of single-bit output lines that a processor reaches during its I/O cycles. The line to act on is not carried on the data bus. It comes from the low six bits of the processor's RAM address register, which sit on the address bus while the I/O request is active. The command offset is one bit. An odd offset writes the level of one stored line. An even offset turns the whole output bank on or off.

Bit 3 of the write data carries the level in both commands. When the bank is switched off, the external outputs are held inactive, but the stored levels are kept. Switching the bank back on shows every stored level again at once.

During the same cycle the block returns a 4-bit read-back value. It reports the level of the addressed input line as 4'hF for high and 4'h7 for low. An index that names no line also reads as 4'hF. A system can place two of these blocks side by side, one serving the lower memory region and one the upper.

Top module: `dio_line_ctrl`

## Requirements
- R1: While reset is asserted, and after it is released, every stored line is 0, the bank enable is low and all 16 outputs read 0.
- R2: A strobed command with the odd offset (cmd_odd=1), data bit 3 high and an index below 16 stores a 1 in that line from the next clock edge. Data bits 2:0 have no effect.
- R3: A strobed odd-offset command with data bit 3 low and an index below 16 stores a 0 in that line. Data bits 2:0 have no effect.
- R4: A strobed odd-offset command with an index of 16 to 63 leaves every stored line and the bank enable unchanged.
- R5: A line-write command changes only the addressed line. The other 15 keep their stored values.
- R6: A strobed command with the even offset (cmd_odd=0) and data bit 3 high turns the bank on. From the next edge, out_lines equals all 16 stored values.
- R7: A strobed even-offset command with data bit 3 low turns the bank off. From the next edge, out_lines is all zero. Stored values are kept, and they reappear when the bank is turned on again.
- R8: An even-offset command never alters the stored line values.
- R9: rd_data is 4'hF when the indexed input line is high or the index is 16 or more, and 4'h7 when the indexed input is low. It follows the inputs within the same cycle.
- R10: With the strobe low, no input changes the stored lines or the bank enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_strobe | input | 1 | I/O request strobe, one command per high cycle |
| cmd_odd | input | 1 | Command offset bit: 1 writes a line level, 0 sets the bank enable |
| wr_data | input | 4 | Write data; bit 3 is the level or enable value |
| line_idx | input | 6 | Line index from the address register low bits |
| in_lines | input | 16 | External input line levels |
| out_lines | output | 16 | Output line levels after bank gating |
| outputs_enabled | output | 1 | Bank enable state |
| rd_data | output | 4 | Read-back code for the indexed input |

## Verification
A wrong stored line is hidden while the bank is off. It shows on out_lines at the first edge after an enable command, so the bench turns the bank off and back on to expose lines that were written while it was disabled. A decode fault that hits a neighbouring line, or that lets an out-of-range index wrap onto line 0 to 15, changes out_lines one edge after the offending write. A read-back fault shows in the same cycle the index is presented, because that path holds no register.

// File: rtl/dio_pkg.sv
package dio_pkg;

   typedef enum logic {
      CMD_BANK_ENABLE = 1'b0,
      CMD_LINE_LEVEL  = 1'b1
   } dio_cmd_e;

   localparam int unsigned LEVEL_BIT = 3;

   localparam logic [3:0] RD_CODE_HIGH = 4'hF;
   localparam logic [3:0] RD_CODE_LOW  = 4'h7;

endpackage

// File: rtl/dio_index_decode.sv
module dio_index_decode #(
   parameter int unsigned NUM_LINES = 16,
   parameter int unsigned IDX_W     = 6
) (
   input  logic [IDX_W-1:0]     idx,
   output logic [NUM_LINES-1:0] sel,
   output logic                 in_range
);

   if (NUM_LINES > (1 << IDX_W)) begin : g_bad_width
      $error("dio_index_decode: index too narrow for line count");
   end

   for (genvar i = 0; i < NUM_LINES; i++) begin : g_sel
      assign sel[i] = (idx == IDX_W'(i));
   end

   assign in_range = |sel;

endmodule

// File: rtl/dio_line_bank.sv
module dio_line_bank
   import dio_pkg::*;
#(
   parameter int unsigned NUM_LINES = 16,
   parameter int unsigned DATA_W    = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 strobe,
   input  dio_cmd_e             cmd,
   input  logic [DATA_W-1:0]    wr_data,
   input  logic [NUM_LINES-1:0] sel,
   output logic [NUM_LINES-1:0] line_q,
   output logic                 enable_q
);

   if (DATA_W <= LEVEL_BIT) begin : g_bad_data
      $error("dio_line_bank: data too narrow for level bit");
   end

   logic level;
   logic line_cmd;
   logic bank_cmd;

   assign level    = wr_data[LEVEL_BIT];
   assign line_cmd = strobe && (cmd == CMD_LINE_LEVEL);
   assign bank_cmd = strobe && (cmd == CMD_BANK_ENABLE);

   for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            line_q[i] <= 1'b0;
         end else if (line_cmd && sel[i]) begin
            line_q[i] <= level;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         enable_q <= 1'b0;
      end else if (bank_cmd) begin
         enable_q <= level;
      end
   end

   assert_line_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (line_cmd && level) |=> ((line_q & $past(sel)) == $past(sel)));

   assert_line_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (line_cmd && !level) |=> ((line_q & $past(sel)) == '0));

   assert_oor_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (line_cmd && (sel == '0)) |=> ($stable(line_q) && $stable(enable_q)));

   assert_others_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
      line_cmd |=> ((line_q & ~$past(sel)) == ($past(line_q) & ~$past(sel))));

   assert_bank_on_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (bank_cmd && level) |=> enable_q);

   assert_bank_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (bank_cmd && !level) |=> !enable_q);

   assert_bank_keeps_lines_R8: assert property (@(posedge clk) disable iff (!rst_n)
      bank_cmd |=> $stable(line_q));

   assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !strobe |=> ($stable(line_q) && $stable(enable_q)));

endmodule

// File: rtl/dio_readback.sv
module dio_readback
   import dio_pkg::*;
#(
   parameter int unsigned NUM_LINES = 16
) (
   input  logic [NUM_LINES-1:0] in_lines,
   input  logic [NUM_LINES-1:0] sel,
   input  logic                 in_range,
   output logic [3:0]           rd_data
);

   logic hit;

   assign hit     = |(in_lines & sel);
   assign rd_data = (!in_range || hit) ? RD_CODE_HIGH : RD_CODE_LOW;

endmodule

// File: rtl/dio_line_ctrl.sv
module dio_line_ctrl
   import dio_pkg::*;
#(
   parameter int unsigned NUM_LINES = 16,
   parameter int unsigned IDX_W     = 6,
   parameter int unsigned DATA_W    = 4,
   parameter bit          GATE_OUT  = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 io_strobe,
   input  logic                 cmd_odd,
   input  logic [DATA_W-1:0]    wr_data,
   input  logic [IDX_W-1:0]     line_idx,
   input  logic [NUM_LINES-1:0] in_lines,
   output logic [NUM_LINES-1:0] out_lines,
   output logic                 outputs_enabled,
   output logic [3:0]           rd_data
);

   localparam int unsigned SEL_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;

   if (SEL_W > IDX_W) begin : g_bad_idx
      $error("dio_line_ctrl: IDX_W cannot address NUM_LINES");
   end

   logic [NUM_LINES-1:0] sel;
   logic                 in_range;
   logic [NUM_LINES-1:0] line_q;
   logic                 enable_q;

   dio_index_decode #(
      .NUM_LINES (NUM_LINES),
      .IDX_W     (IDX_W)
   ) u_decode (
      .idx      (line_idx),
      .sel      (sel),
      .in_range (in_range)
   );

   dio_line_bank #(
      .NUM_LINES (NUM_LINES),
      .DATA_W    (DATA_W)
   ) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .strobe   (io_strobe),
      .cmd      (dio_cmd_e'(cmd_odd)),
      .wr_data  (wr_data),
      .sel      (sel),
      .line_q   (line_q),
      .enable_q (enable_q)
   );

   dio_readback #(
      .NUM_LINES (NUM_LINES)
   ) u_rdback (
      .in_lines (in_lines),
      .sel      (sel),
      .in_range (in_range),
      .rd_data  (rd_data)
   );

   if (GATE_OUT) begin : g_gated
      assign out_lines = enable_q ? line_q : '0;
   end else begin : g_ungated
      assign out_lines = line_q;
   end

   assign outputs_enabled = enable_q;

   assert_decode_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
      in_range |-> ($countones(sel) == 1));

   assert_decode_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (line_idx >= IDX_W'(NUM_LINES)) |-> !in_range);

   assert_rd_oor_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !in_range |-> (rd_data == RD_CODE_HIGH));

   assert_reset_state_R1: assert property (@(posedge clk)
      !rst_n |-> (line_q == '0 && !enable_q));

endmodule

// File: tb/sim_dio_line_ctrl.sv
module sim_dio_line_ctrl;

   localparam int CLK_PERIOD = 10;

   typedef struct {
      logic [15:0] out;
      logic        en;
      logic [3:0]  rd;
      string       req;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        io_strobe = 1'b0;
   logic        cmd_odd = 1'b0;
   logic [3:0]  wr_data = '0;
   logic [5:0]  line_idx = '0;
   logic [15:0] in_lines = '0;
   logic [15:0] out_lines;
   logic        outputs_enabled;
   logic [3:0]  rd_data;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   logic [15:0] m_lines = '0;
   logic        m_en = 1'b0;
   exp_t        sb[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   dio_line_ctrl u0 (
      .clk             (clk),
      .rst_n           (rst_n),
      .io_strobe       (io_strobe),
      .cmd_odd         (cmd_odd),
      .wr_data         (wr_data),
      .line_idx        (line_idx),
      .in_lines        (in_lines),
      .out_lines       (out_lines),
      .outputs_enabled (outputs_enabled),
      .rd_data         (rd_data)
   );

   task automatic step(input logic stb, input logic odd, input logic [3:0] d,
                       input logic [5:0] idx, input logic [15:0] inl, input string req);
      exp_t e;
      @(negedge clk);
      io_strobe = stb;
      cmd_odd   = odd;
      wr_data   = d;
      line_idx  = idx;
      in_lines  = inl;
      if (stb && rst_n) begin
         if (odd) begin
            if (idx < 16) m_lines[idx[3:0]] = d[3];
         end else begin
            m_en = d[3];
         end
      end
      e.out = m_en ? m_lines : 16'h0;
      e.en  = m_en;
      e.rd  = (idx >= 16 || inl[idx[3:0]]) ? 4'hF : 4'h7;
      e.req = req;
      sb.push_back(e);
   endtask

   initial begin : monitor
      forever begin
         @(posedge clk);
         #1;
         if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            checks++;
            if (out_lines !== e.out || outputs_enabled !== e.en || rd_data !== e.rd) begin
               errors++;
               $display("FAIL %s: out=%h en=%b rd=%h expected out=%h en=%b rd=%h",
                        e.req, out_lines, outputs_enabled, rd_data, e.out, e.en, e.rd);
            end
         end
      end
   end

   initial begin : watchdog
      #(CLK_PERIOD * 20000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: run did not complete");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin : driver
      // R1: state during reset, even with a strobed write present
      step(1'b1, 1'b1, 4'h8, 6'd2, 16'h0000, "R1");
      step(1'b0, 1'b0, 4'h0, 6'd2, 16'h0004, "R1");
      @(negedge clk);
      rst_n = 1'b1;
      step(1'b0, 1'b0, 4'h0, 6'd0, 16'h0000, "R1");
      // R6: bank on with nothing stored
      step(1'b1, 1'b0, 4'h8, 6'd0, 16'h0000, "R6");
      // R2: set lines, low data bits ignored
      step(1'b1, 1'b1, 4'h8, 6'd5, 16'h0000, "R2");
      step(1'b1, 1'b1, 4'hF, 6'd15, 16'h0000, "R2");
      step(1'b1, 1'b1, 4'h9, 6'd0, 16'h0000, "R2");
      // R3 / R5: clear line 5 only
      step(1'b1, 1'b1, 4'h7, 6'd5, 16'h0000, "R3");
      step(1'b1, 1'b1, 4'h8, 6'd6, 16'h0000, "R5");
      // R4: out-of-range indices change nothing, incl. aliases of 0 and 1
      step(1'b1, 1'b1, 4'h8, 6'd16, 16'h0000, "R4");
      step(1'b1, 1'b1, 4'h0, 6'd48, 16'h0000, "R4");
      step(1'b1, 1'b1, 4'h8, 6'd33, 16'h0000, "R4");
      // R10: no strobe, no change
      step(1'b0, 1'b1, 4'h0, 6'd0, 16'h0000, "R10");
      step(1'b0, 1'b0, 4'h0, 6'd0, 16'h0000, "R10");
      // R7: bank off hides lines
      step(1'b1, 1'b0, 4'h7, 6'd3, 16'h0000, "R7");
      // R2 while off: stored but not shown
      step(1'b1, 1'b1, 4'h8, 6'd3, 16'h0000, "R2");
      // R6 / R8: re-enable shows lines 0,3,6,15 unchanged by bank commands
      step(1'b1, 1'b0, 4'hF, 6'd9, 16'h0000, "R8");
      step(1'b0, 1'b0, 4'h0, 6'd0, 16'h0000, "R6");
      // R9: read-back codes
      step(1'b0, 1'b0, 4'h0, 6'd4, 16'h0010, "R9");
      step(1'b0, 1'b0, 4'h0, 6'd4, 16'hFFEF, "R9");
      step(1'b0, 1'b0, 4'h0, 6'd15, 16'h8000, "R9");
      step(1'b0, 1'b0, 4'h0, 6'd20, 16'h0000, "R9");
      step(1'b0, 1'b0, 4'h0, 6'd63, 16'h0000, "R9");
      step(1'b1, 1'b1, 4'h0, 6'd0, 16'h0000, "R9");
      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule